// File: doc/BRIEF.md
# Parallel Slave Port Controller

This block lets an external bus master exchange bytes with a local processor through a small set of mailbox registers. The master side has a chip select, read and write strobes, an 8-bit data bus and an address-latch strobe. When that strobe fires, the block latches a register-select bit. Depending on a control field, the bit comes either from a dedicated address line (for a demultiplexed bus) or from bit 1 of the data bus (for a multiplexed address/data bus). The local side is a plain register interface. Through it the local processor programs the control register, reads the status flags, collects commands and input bytes, and posts output bytes.

The block tracks three handshake flags: command-buffer-empty, input-buffer-empty and output-buffer-full. It routes each master access to the command/status pair or to the data pair, and raises an interrupt toward the master. In standard mode, per-flag masks gate the interrupt. In shared-memory mode, register-select is ignored, the masks are ignored, and every master access goes to the data pair. Master strobes pass through a synchronizer, and each access acts once, on the rising edge of its synchronized strobe.

Local register map (local address): 0 control, 1 status, 2 command buffer, 3 data (reads return the input buffer, writes fill the output buffer). Control fields: bit 4 shared-memory mode, bit 3 port enable, bit 2 select source (0 = address line, 1 = data bit 1), bit 1 input-empty interrupt enable, bit 0 output-full interrupt enable. Status fields: bit 0 output-buffer-full, bit 1 input-buffer-empty, bit 2 command-buffer-empty, all other bits 0.

Top module: `slave_port_ctl`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x00 and the interrupt is low.
- R2: While the enable bit (control bit 3) is 0, all three status flags are held at 0, including flags that were set before the port was disabled.
- R3: In standard mode with register-select high, a master write loads the command buffer and clears command-buffer-empty (status bit 2), and a master read returns the status register without changing any flag.
- R4: In standard mode with register-select low, a master write loads the input buffer and clears input-buffer-empty (status bit 1), and a master read returns the output buffer and clears output-buffer-full (status bit 0).
- R5: On the rising edge of the synchronized address-latch strobe, register-select is captured from the address-line input when control bit 2 is 0, and from data bit 1 when control bit 2 is 1. Between such edges it holds its value.
- R6: In shared-memory mode (control bit 4 = 1), register-select has no effect: master writes load the input buffer, master reads return the output buffer, and the command buffer is unchanged.
- R7: A local write to address 3 sets output-buffer-full. A local read of address 3 sets input-buffer-empty. A local read of address 2 sets command-buffer-empty.
- R8: In standard mode the interrupt, one cycle after the flags, equals (input-buffer-empty AND control bit 1) OR (output-buffer-full AND control bit 0).
- R9: In shared-memory mode the interrupt, one cycle after the flags, equals input-buffer-empty OR output-buffer-full, whatever the mask bits hold.
- R10: While the port is disabled, master writes change neither the command buffer nor the input buffer.
- R11: Control bits 7:5 are not stored and always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mst_cs_n | input | 1 | Master chip select, active low |
| mst_rd_n | input | 1 | Master read strobe, active low |
| mst_wr_n | input | 1 | Master write strobe, active low |
| mst_ale | input | 1 | Master address-latch strobe, active high |
| mst_a1 | input | 1 | Master address line used as select source when control bit 2 is 0 |
| mst_din | input | DATA_W | Master write data; bit 1 is the select source when control bit 2 is 1 |
| mst_dout | output | DATA_W | Data returned to the master: status or output buffer |
| mst_irq | output | 1 | Registered interrupt to the master |
| loc_addr | input | 2 | Local register address |
| loc_wr | input | 1 | Local write strobe, one cycle |
| loc_rd | input | 1 | Local read strobe, one cycle; triggers read side effects |
| loc_wdata | input | DATA_W | Local write data |
| loc_rdata | output | DATA_W | Local read data for loc_addr |

## Verification
The bench builds the block with its defaults: an 8-bit data path and a two-stage synchronizer. With the 8-bit width, every master and local byte value can be compared directly with literal expectations. With two synchronizer stages, the strobe-to-effect latency stays short enough that each master access finishes within a few cycles of holding the strobes. The bench drives the select bit through both sources, with the unused source set to the opposite value. It also toggles mode, masks and enable while flags are set, so that each interrupt term and each forced clear is observed.

// File: rtl/slave_port_pkg.sv
package slave_port_pkg;

    typedef struct packed {
        logic shared;
        logic enable;
        logic sel_src;
        logic ibe_irq_en;
        logic obf_irq_en;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    typedef enum logic [1:0] {
        ADDR_CTL  = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_CMD  = 2'd2,
        ADDR_DATA = 2'd3
    } loc_addr_e;

    localparam int STAT_OBF = 0;
    localparam int STAT_IBE = 1;
    localparam int STAT_CBE = 2;

endpackage

// File: rtl/slave_port_sync.sv
module slave_port_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[0] <= 1'b0;
                else        chain_q[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[i] <= 1'b0;
                else        chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/slave_port_strobe.sv
module slave_port_strobe #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic synced;
    logic prev_d, prev_q;

    slave_port_sync #(.STAGES(STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (level),
        .q    (synced)
    );

    always_comb begin
        prev_d = synced;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise = synced & ~prev_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R3
endmodule

// File: rtl/slave_port_sel.sv
module slave_port_sel #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ale,
    input  logic a1,
    input  logic ad1,
    input  logic from_data,
    output logic sel
);
    logic ale_rise;
    logic sel_d, sel_q;

    slave_port_strobe #(.STAGES(STAGES)) i_ale (
        .clk  (clk),
        .rst_n(rst_n),
        .level(ale),
        .rise (ale_rise)
    );

    always_comb begin
        sel_d = sel_q;
        if (ale_rise) begin
            sel_d = from_data ? ad1 : a1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= 1'b0;
        else        sel_q <= sel_d;
    end

    assign sel = sel_q;

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ale_rise |=> $stable(sel_q)); // R5
    AST_SEL_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (ale_rise && from_data) |=> (sel_q == $past(ad1))); // R5
endmodule

// File: rtl/slave_port_ctl.sv
module slave_port_ctl
    import slave_port_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mst_cs_n,
    input  logic              mst_rd_n,
    input  logic              mst_wr_n,
    input  logic              mst_ale,
    input  logic              mst_a1,
    input  logic [DATA_W-1:0] mst_din,
    output logic [DATA_W-1:0] mst_dout,
    output logic              mst_irq,
    input  logic [1:0]        loc_addr,
    input  logic              loc_wr,
    input  logic              loc_rd,
    input  logic [DATA_W-1:0] loc_wdata,
    output logic [DATA_W-1:0] loc_rdata
);
    localparam int PAD_W = DATA_W - CTL_W;

    typedef struct packed {
        ctl_t              ctl;
        logic              cbe;
        logic              ibe;
        logic              obf;
        logic [DATA_W-1:0] cmd;
        logic [DATA_W-1:0] ibuf;
        logic [DATA_W-1:0] obuf;
        logic              irq;
    } state_t;

    state_t st_d, st_q;

    logic wr_rise, rd_rise, sel_raw, eff_sel;
    logic [DATA_W-1:0] stat_vec;

    slave_port_strobe #(.STAGES(SYNC_STAGES)) i_wr (
        .clk  (clk),
        .rst_n(rst_n),
        .level(~mst_cs_n & ~mst_wr_n),
        .rise (wr_rise)
    );

    slave_port_strobe #(.STAGES(SYNC_STAGES)) i_rd (
        .clk  (clk),
        .rst_n(rst_n),
        .level(~mst_cs_n & ~mst_rd_n),
        .rise (rd_rise)
    );

    slave_port_sel #(.STAGES(SYNC_STAGES)) i_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .ale      (mst_ale),
        .a1       (mst_a1),
        .ad1      (mst_din[1]),
        .from_data(st_q.ctl.sel_src),
        .sel      (sel_raw)
    );

    assign eff_sel = sel_raw & ~st_q.ctl.shared;

    always_comb begin
        stat_vec           = '0;
        stat_vec[STAT_OBF] = st_q.obf;
        stat_vec[STAT_IBE] = st_q.ibe;
        stat_vec[STAT_CBE] = st_q.cbe;
    end

    always_comb begin
        st_d = st_q;
        // local side
        if (loc_wr) begin
            case (loc_addr)
                ADDR_CTL:  st_d.ctl = ctl_t'(loc_wdata[CTL_W-1:0]);
                ADDR_DATA: begin
                    st_d.obuf = loc_wdata;
                    st_d.obf  = 1'b1;
                end
                default: ;
            endcase
        end
        if (loc_rd) begin
            case (loc_addr)
                ADDR_CMD:  st_d.cbe = 1'b1;
                ADDR_DATA: st_d.ibe = 1'b1;
                default: ;
            endcase
        end
        // master side
        if (st_q.ctl.enable) begin
            if (wr_rise) begin
                if (eff_sel) begin
                    st_d.cmd = mst_din;
                    st_d.cbe = 1'b0;
                end else begin
                    st_d.ibuf = mst_din;
                    st_d.ibe  = 1'b0;
                end
            end
            if (rd_rise && !eff_sel) begin
                st_d.obf = 1'b0;
            end
        end else begin
            st_d.cbe = 1'b0;
            st_d.ibe = 1'b0;
            st_d.obf = 1'b0;
        end
        // interrupt
        if (st_q.ctl.shared) begin
            st_d.irq = st_q.ibe | st_q.obf;
        end else begin
            st_d.irq = (st_q.ibe & st_q.ctl.ibe_irq_en) |
                       (st_q.obf & st_q.ctl.obf_irq_en);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mst_dout = eff_sel ? stat_vec : st_q.obuf;
    assign mst_irq  = st_q.irq;

    always_comb begin
        case (loc_addr)
            ADDR_CTL:  loc_rdata = {{PAD_W{1'b0}}, st_q.ctl};
            ADDR_STAT: loc_rdata = stat_vec;
            ADDR_CMD:  loc_rdata = st_q.cmd;
            default:   loc_rdata = st_q.ibuf;
        endcase
    end

    AST_OFF_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctl.enable |=> (stat_vec == '0)); // R2
    AST_CMD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rise && st_q.ctl.enable && eff_sel) |=>
        (st_q.cmd == $past(mst_din) && !st_q.cbe)); // R3
    AST_IBUF_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rise && st_q.ctl.enable && !eff_sel) |=>
        (st_q.ibuf == $past(mst_din) && !st_q.ibe)); // R4
    AST_SHARED_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctl.shared |=> $stable(st_q.cmd)); // R6
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.ibe || st_q.obf) |=> !mst_irq); // R8
    AST_IRQ_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctl.shared && (st_q.ibe || st_q.obf)) |=> mst_irq); // R9
    AST_OFF_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctl.enable |=> ($stable(st_q.cmd) && $stable(st_q.ibuf))); // R10
endmodule

// File: tb/test_slave_port_ctl.sv
`timescale 1ns/1ps
module test_slave_port_ctl;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mst_cs_n = 1'b1, mst_rd_n = 1'b1, mst_wr_n = 1'b1;
    logic          mst_ale = 1'b0, mst_a1 = 1'b0;
    logic [DW-1:0] mst_din = '0;
    logic [DW-1:0] mst_dout;
    logic          mst_irq;
    logic [1:0]    loc_addr = 2'd0;
    logic          loc_wr = 1'b0, loc_rd = 1'b0;
    logic [DW-1:0] loc_wdata = '0;
    logic [DW-1:0] loc_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int            src;   // 0 local read data, 1 master data, 2 interrupt
        logic [DW-1:0] exp;
        string         tag;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    slave_port_ctl #(.DATA_W(DW), .SYNC_STAGES(2)) i_slave_port_ctl (
        .clk(clk), .rst_n(rst_n),
        .mst_cs_n(mst_cs_n), .mst_rd_n(mst_rd_n), .mst_wr_n(mst_wr_n),
        .mst_ale(mst_ale), .mst_a1(mst_a1), .mst_din(mst_din),
        .mst_dout(mst_dout), .mst_irq(mst_irq),
        .loc_addr(loc_addr), .loc_wr(loc_wr), .loc_rd(loc_rd),
        .loc_wdata(loc_wdata), .loc_rdata(loc_rdata)
    );

    // monitor: pops expected items and compares against live outputs
    always @(negedge clk) begin
        item_t it;
        logic [DW-1:0] act;
        if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            case (it.src)
                0:       act = loc_rdata;
                1:       act = mst_dout;
                default: act = {{(DW-1){1'b0}}, mst_irq};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual %02h expected %02h", it.tag, act, it.exp);
            end
        end
    end

    task automatic expect_item(input int src, input logic [1:0] addr,
                               input logic [DW-1:0] exp, input string tag);
        item_t it;
        @(posedge clk); #1;
        loc_addr = addr;
        it.src = src; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic loc_write(input logic [1:0] addr, input logic [DW-1:0] data);
        @(posedge clk); #1;
        loc_addr = addr; loc_wdata = data; loc_wr = 1'b1;
        @(posedge clk); #1;
        loc_wr = 1'b0;
    endtask

    task automatic loc_read_pulse(input logic [1:0] addr);
        @(posedge clk); #1;
        loc_addr = addr; loc_rd = 1'b1;
        @(posedge clk); #1;
        loc_rd = 1'b0;
    endtask

    task automatic latch_sel(input logic val, input logic via_data);
        @(posedge clk); #1;
        mst_a1  = via_data ? ~val : val;
        mst_din = '0;
        mst_din[1] = via_data ? val : ~val;
        mst_ale = 1'b1;
        repeat (5) @(posedge clk);
        #1 mst_ale = 1'b0;
        repeat (5) @(posedge clk);
    endtask

    task automatic mst_write(input logic [DW-1:0] data);
        @(posedge clk); #1;
        mst_din = data; mst_cs_n = 1'b0; mst_wr_n = 1'b0;
        repeat (5) @(posedge clk);
        #1 mst_wr_n = 1'b1; mst_cs_n = 1'b1;
        repeat (5) @(posedge clk);
    endtask

    task automatic mst_read_expect(input logic [DW-1:0] exp, input string tag);
        @(posedge clk); #1;
        mst_cs_n = 1'b0; mst_rd_n = 1'b0;
        repeat (4) @(posedge clk);
        expect_item(1, 2'd1, exp, tag);
        mst_rd_n = 1'b1; mst_cs_n = 1'b1;
        repeat (5) @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        expect_item(0, 2'd0, 8'h00, "R1 control after reset");
        expect_item(0, 2'd1, 8'h00, "R1 status after reset");
        expect_item(2, 2'd0, 8'h00, "R1 irq after reset");

        // enable, standard mode, address-line source, masks off
        loc_write(2'd0, 8'h08);
        expect_item(0, 2'd1, 8'h00, "R2 flags clear after enable");
        loc_write(2'd3, 8'h5A);
        expect_item(0, 2'd1, 8'h01, "R7 local write sets output full");
        expect_item(2, 2'd0, 8'h00, "R8 masked flags give no irq");

        // data pair via address line
        latch_sel(1'b0, 1'b0);
        mst_read_expect(8'h5A, "R4 master read returns output buffer");
        expect_item(0, 2'd1, 8'h00, "R4 master read clears output full");
        loc_read_pulse(2'd3);
        expect_item(0, 2'd1, 8'h02, "R7 local data read sets input empty");
        loc_read_pulse(2'd2);
        expect_item(0, 2'd1, 8'h06, "R7 local cmd read sets command empty");
        mst_write(8'h3C);
        expect_item(0, 2'd3, 8'h3C, "R4 master write loads input buffer");
        expect_item(0, 2'd1, 8'h04, "R4 master write clears input empty");

        // command pair via address line
        latch_sel(1'b1, 1'b0);
        mst_write(8'hA7);
        expect_item(0, 2'd2, 8'hA7, "R3 master write loads command");
        expect_item(0, 2'd1, 8'h00, "R3 master write clears command empty");
        loc_write(2'd3, 8'h11);
        mst_read_expect(8'h01, "R3 master read returns status");
        expect_item(0, 2'd1, 8'h01, "R3 status read keeps flags");

        // interrupt masks in standard mode
        loc_write(2'd0, 8'h0B);
        expect_item(2, 2'd0, 8'h01, "R8 output full with mask on raises irq");
        loc_write(2'd0, 8'h0A);
        expect_item(2, 2'd0, 8'h00, "R8 output full with mask off no irq");
        loc_read_pulse(2'd3);
        expect_item(2, 2'd0, 8'h01, "R8 input empty with mask on raises irq");

        // data-bit source
        loc_write(2'd0, 8'h0C);
        expect_item(2, 2'd0, 8'h00, "R8 both masks off no irq");
        latch_sel(1'b1, 1'b1);
        mst_write(8'h77);
        expect_item(0, 2'd2, 8'h77, "R5 data-bit source selects command");
        latch_sel(1'b0, 1'b1);
        mst_write(8'h44);
        expect_item(0, 2'd3, 8'h44, "R5 data-bit source selects data");
        expect_item(0, 2'd2, 8'h77, "R5 command untouched by data write");

        // shared-memory mode, masks off
        loc_write(2'd0, 8'h18);
        expect_item(2, 2'd0, 8'h01, "R9 shared irq ignores masks");
        latch_sel(1'b1, 1'b0);
        mst_write(8'h99);
        expect_item(0, 2'd3, 8'h99, "R6 shared write goes to input buffer");
        expect_item(0, 2'd2, 8'h77, "R6 shared write leaves command");
        mst_read_expect(8'h11, "R6 shared read returns output buffer");
        expect_item(0, 2'd1, 8'h00, "R6 shared read clears output full");
        expect_item(2, 2'd0, 8'h00, "R9 shared irq drops with flags");

        // disable while a flag is set
        loc_write(2'd3, 8'h22);
        expect_item(0, 2'd1, 8'h01, "R7 output full before disable");
        loc_write(2'd0, 8'h00);
        expect_item(0, 2'd1, 8'h00, "R2 disable clears flags");
        mst_write(8'hEE);
        expect_item(0, 2'd3, 8'h99, "R10 disabled write ignored input buffer");
        expect_item(0, 2'd2, 8'h77, "R10 disabled write ignored command");

        // reserved control bits
        loc_write(2'd0, 8'hFF);
        expect_item(0, 2'd0, 8'h1F, "R11 reserved control bits read zero");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule